// File: doc/BRIEF.md
# Eight-Channel Down-Counting Timer Bank

This block holds eight independent 32-bit down-counters behind a small word-addressed register port. Each channel has four registers: a live count (status), a reload value, and two compare values. The run, tick-source, interrupt-enable and waveform bits of every channel are packed into one shared control word, four bits per channel. A separate clear word drops selected control bits without a read-modify-write.

A running channel counts down either on every system clock cycle or only on cycles where the external 1 MHz strobe is high. On a step taken while the count is zero, the channel reloads. If the channel's interrupt bit is set, it also emits a one-cycle interrupt pulse. Stopping a channel by clearing its run bit copies the reload value into the count. Software can therefore read elapsed ticks as reload minus status. The two compare values drive level flags that are high while the count equals them.

Top module: `tmr_bank`

## Requirements
- R1: After reset every count, reload, compare value, the control word and all interrupt outputs are zero, so both compare flag vectors read all ones.
- R2: Channel n (1..8) owns control bits 4n-4..4n-1. In that nibble, bit 0 is run, bit 1 selects the 1 MHz strobe as tick source, bit 2 enables the wrap interrupt and bit 3 is a stored waveform-mode bit. Bit 3 is kept only for channels 1..4 and reads zero for channels 5..8.
- R3: Word address 4(n-1)+k serves channels 1..3, and 16+4(n-4)+k serves channels 4..8. In both, k=0 is the count, k=1 reload, k=2 compare 1 and k=3 compare 2. Address 12 is the control word, 13 and 14 are reserved (they read zero and ignore writes), and 15 is the clear word (it reads zero). Any other address reads zero.
- R4: A control write or clear that takes a channel's run bit from 1 to 0 loads the channel's reload value into its count at that edge.
- R5: A running channel with bit 1 clear decrements by one on every clock cycle.
- R6: A running channel with bit 1 set decrements only on cycles where tick_1mhz is high.
- R7: A step taken at count zero loads the reload value. The channel's irq bit is high for the following cycle only if the channel's bit 2 was set.
- R8: A write to the clear word clears every control bit that is 1 in the written data and leaves the rest unchanged.
- R9: Writes to a channel's count word are ignored.
- R10: match1_hit[n-1] is high exactly while channel n's count equals its compare 1 value; match2_hit behaves the same way for compare 2.
- R11: When a run-bit clear lands in the same cycle as a step at zero, the count takes the reload value and no interrupt is raised.
- R12: A stopped channel holds its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1mhz | input | 1 | One-cycle 1 MHz tick strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr (combinational) |
| irq | output | 8 | Per-channel wrap interrupt pulses |
| match1_hit | output | 8 | Count equals compare 1, per channel |
| match2_hit | output | 8 | Count equals compare 2, per channel |

## Verification
Two events can fall in the same cycle: a software stop, which loads the reload value, and a step at zero, which wraps the count and may raise an interrupt. The bench runs a channel with its interrupt enabled down to zero. It then times the run-bit clear so that the clear lands on the very edge where the wrap step would happen. It judges the result by reading the count, which must equal the reload value, and by checking that the interrupt output stayed low, and then that the count holds on later cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam logic [4:0] LOW_CH     = 5'd3;
    localparam logic [7:0] CTRL_ADDR  = 8'd12;
    localparam logic [7:0] CLR_ADDR   = 8'd15;
    localparam logic [7:0] HIGH_BASE  = 8'd16;

    typedef enum logic [1:0] {
        RK_STATUS = 2'd0,
        RK_RELOAD = 2'd1,
        RK_CMP1   = 2'd2,
        RK_CMP2   = 2'd3
    } reg_kind_e;

    // One channel's control nibble; bit 0 is run.
    typedef struct packed {
        logic pwm;
        logic wrap_ie;
        logic use_1m;
        logic run;
    } chcfg_t;

    typedef struct packed {
        logic      hit;
        logic [4:0] ch;
        reg_kind_e kind;
    } dec_t;

    // Maps a word address to a channel register; the control words sit
    // between the low and high channel groups.
    function automatic dec_t decode(input logic [7:0] a);
        dec_t d;
        logic [7:0] off;
        d   = '{hit: 1'b0, ch: 5'd0, kind: RK_STATUS};
        off = a - HIGH_BASE;
        if (a < CTRL_ADDR) begin
            d.hit  = 1'b1;
            d.ch   = {1'b0, a[5:2]};
            d.kind = reg_kind_e'(a[1:0]);
        end else if (a >= HIGH_BASE) begin
            d.hit  = 1'b1;
            d.ch   = 5'(6'(LOW_CH) + off[7:2]);
            d.kind = reg_kind_e'(off[1:0]);
        end
        return d;
    endfunction

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl #(
    parameter int N_CH   = 8,
    parameter int PWM_CH = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_ctrl,
    input  logic                wr_clr,
    input  logic [4*N_CH-1:0]   wdata,
    output logic [4*N_CH-1:0]   ctrl_q,
    output logic [N_CH-1:0]     run_fall
);
    localparam int CW = 4 * N_CH;

    function automatic logic [CW-1:0] keep_mask();
        logic [CW-1:0] m;
        m = '1;
        for (int i = 0; i < N_CH; i++) begin
            if (i >= PWM_CH) m[4*i+3] = 1'b0;
        end
        return m;
    endfunction

    localparam logic [CW-1:0] KEEP = keep_mask();

    logic [CW-1:0] nxt;

    always_comb begin
        nxt = ctrl_q;
        if (wr_ctrl)     nxt = wdata;
        else if (wr_clr) nxt = ctrl_q & ~wdata;
        nxt = nxt & KEEP;
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_fall
        assign run_fall[i] = ctrl_q[4*i] & ~nxt[4*i];
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= nxt;
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  chcfg_t           cfg,
    input  logic             tick_1mhz,
    input  logic             disable_load,
    input  logic             reload_we,
    input  logic             cmp1_we,
    input  logic             cmp2_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cmp1,
    output logic [CNT_W-1:0] cmp2,
    output logic             irq,
    output logic             hit1,
    output logic             hit2
);
    logic step;
    logic at_zero;
    logic unused_pwm;

    assign unused_pwm = cfg.pwm;

    always_comb begin
        step    = cfg.run && (cfg.use_1m ? tick_1mhz : 1'b1);
        at_zero = (count == '0);
    end

    assign hit1 = (count == cmp1);
    assign hit2 = (count == cmp2);

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            reload <= '0;
            cmp1   <= '0;
            cmp2   <= '0;
            irq    <= 1'b0;
        end else begin
            if (reload_we) reload <= wdata;
            if (cmp1_we)   cmp1   <= wdata;
            if (cmp2_we)   cmp2   <= wdata;
            irq <= step && at_zero && cfg.wrap_ie && !disable_load;
            if (disable_load)  count <= reload;
            else if (step)     count <= at_zero ? reload : count - 1'b1;
        end
    end

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int N_CH   = 8,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 6,
    parameter int PWM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1mhz,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  rd_data,
    output logic [N_CH-1:0]   irq,
    output logic [N_CH-1:0]   match1_hit,
    output logic [N_CH-1:0]   match2_hit
);
    localparam int CW    = 4 * N_CH;
    localparam int CH_IW = $clog2(N_CH);

    logic [7:0]                  a8;
    dec_t                        dec;
    logic                        ch_ok;
    logic [CH_IW-1:0]            sel;
    logic [CW-1:0]               ctrl_q;
    logic [N_CH-1:0]             run_fall;
    logic [N_CH-1:0][CNT_W-1:0]  cnt_all;
    logic [N_CH-1:0][CNT_W-1:0]  rel_all;
    logic [N_CH-1:0][CNT_W-1:0]  c1_all;
    logic [N_CH-1:0][CNT_W-1:0]  c2_all;

    always_comb begin
        a8    = 8'(addr);
        dec   = decode(a8);
        ch_ok = dec.hit && (int'(dec.ch) < N_CH);
        sel   = dec.ch[CH_IW-1:0];
    end

    tmr_ctrl #(.N_CH(N_CH), .PWM_CH(PWM_CH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_ctrl  (wr_en && a8 == CTRL_ADDR),
        .wr_clr   (wr_en && a8 == CLR_ADDR),
        .wdata    (wr_data[CW-1:0]),
        .ctrl_q   (ctrl_q),
        .run_fall (run_fall)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic wsel;
        assign wsel = wr_en && ch_ok && (int'(dec.ch) == i);

        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk          (clk),
            .rst          (rst),
            .cfg          (chcfg_t'(ctrl_q[4*i +: 4])),
            .tick_1mhz    (tick_1mhz),
            .disable_load (run_fall[i]),
            .reload_we    (wsel && dec.kind == RK_RELOAD),
            .cmp1_we      (wsel && dec.kind == RK_CMP1),
            .cmp2_we      (wsel && dec.kind == RK_CMP2),
            .wdata        (wr_data),
            .count        (cnt_all[i]),
            .reload       (rel_all[i]),
            .cmp1         (c1_all[i]),
            .cmp2         (c2_all[i]),
            .irq          (irq[i]),
            .hit1         (match1_hit[i]),
            .hit2         (match2_hit[i])
        );
    end

    always_comb begin
        rd_data = '0;
        if (ch_ok) begin
            case (dec.kind)
                RK_STATUS: rd_data = cnt_all[sel];
                RK_RELOAD: rd_data = rel_all[sel];
                RK_CMP1:   rd_data = c1_all[sel];
                RK_CMP2:   rd_data = c2_all[sel];
                default:   rd_data = '0;
            endcase
        end else if (a8 == CTRL_ADDR) begin
            rd_data[CW-1:0] = ctrl_q;
        end
    end

endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
    parameter int N_CH  = 8,
    parameter int CNT_W = 32
) (
    input logic                      clk,
    input logic                      rst,
    input logic [4*N_CH-1:0]         ctrl_q,
    input logic [N_CH-1:0]           fall,
    input logic [N_CH-1:0][CNT_W-1:0] cnt_all,
    input logic [N_CH-1:0][CNT_W-1:0] rel_all,
    input logic [N_CH-1:0]           irq
);
    logic unused_ctrl;
    assign unused_ctrl = ^ctrl_q;

    for (genvar g = 0; g < N_CH; g++) begin : g_chk
        AST_DISABLE_LOADS: assert property (@(posedge clk) disable iff (rst)
            fall[g] |=> cnt_all[g] == $past(rel_all[g]))
            else $error("stop did not load reload, ch %0d", g); // R4

        AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
            !ctrl_q[4*g] |=> $stable(cnt_all[g]))
            else $error("stopped count moved, ch %0d", g); // R12

        AST_FREE_DEC: assert property (@(posedge clk) disable iff (rst)
            (ctrl_q[4*g] && !ctrl_q[4*g+1] && cnt_all[g] != '0 && !fall[g])
            |=> cnt_all[g] == CNT_W'($past(cnt_all[g]) - 1'b1))
            else $error("free-run decrement wrong, ch %0d", g); // R5

        AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
            irq[g] |-> ($past(ctrl_q[4*g+2]) && $past(cnt_all[g]) == '0))
            else $error("spurious interrupt, ch %0d", g); // R7
    end

endmodule

bind tmr_bank tmr_bank_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ctrl_q  (ctrl_q),
    .fall    (run_fall),
    .cnt_all (cnt_all),
    .rel_all (rel_all),
    .irq     (irq)
);

// File: tb/tmr_bank_tb.sv
`timescale 1ns/1ps
module tmr_bank_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_1mhz = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [7:0]  irq, match1_hit, match2_hit;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    tmr_bank u_dut (
        .clk(clk), .rst(rst), .tick_1mhz(tick_1mhz), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq),
        .match1_hit(match1_hit), .match2_hit(match2_hit)
    );

    function automatic int chaddr(int n, int k);
        return (n <= 3) ? 4*(n-1)+k : 16 + 4*(n-4) + k;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        addr = 6'(a); wr_data = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        addr = 6'(a); #1; v = rd_data;
    endtask

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    // Puts reload r into channel n and its count, leaving the channel stopped.
    task automatic ld(input int n, input logic [31:0] r);
        wr(chaddr(n,1), r);
        wr(12, 32'h1 << (4*n-4));
        wr(12, 0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(0, v);  chk("R1 count ch1", v, 0);
        rd(chaddr(6,1), v); chk("R1 reload ch6", v, 0);
        rd(12, v); chk("R1 control", v, 0);
        chk("R1 irq", {24'h0, irq}, 0);
        chk("R1 match flags", {16'h0, match1_hit, match2_hit}, 32'hFFFF);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(chaddr(8,1), 32'hCAFE);
        rd(33, v); chk("R3 ch8 reload at 33", v, 32'hCAFE);
        rd(chaddr(4,1), v); chk("R3 ch4 reload untouched", v, 0);
        wr(11, 32'h55);
        rd(11, v); chk("R3 ch3 cmp2 at 11", v, 32'h55);
        wr(13, 32'h1234);
        rd(13, v); chk("R3 reserved 13 reads zero", v, 0);
        rd(14, v); chk("R3 reserved 14 reads zero", v, 0);
        rd(40, v); chk("R3 unmapped reads zero", v, 0);
        wr(11, 0);
        wr(chaddr(8,1), 0);
    endtask

    task automatic t_status_ro();
        logic [31:0] v;
        ld(1, 32'd9);
        wr(0, 32'd1234);
        rd(0, v); chk("R9 count write ignored", v, 32'd9);
    endtask

    task automatic t_ctrl_pack();
        logic [31:0] v;
        wr(12, 32'hFFFF_FFFF);
        rd(12, v); chk("R2 nibble bit3 kept on ch1-4 only", v, 32'h7777_FFFF);
        wr(15, 32'h0000_00F0);
        rd(12, v); chk("R8 clear word drops selected bits", v, 32'h7777_FF0F);
        rd(15, v); chk("R3 clear word reads zero", v, 0);
        wr(12, 0);
    endtask

    task automatic t_free_run();
        logic [31:0] v;
        ld(5, 32'd100);
        wr(12, 32'h1 << 16);
        step(5);
        rd(chaddr(5,0), v); chk("R5 sysclk decrement", v, 32'd95);
        wr(12, 0);
        rd(chaddr(5,0), v); chk("R4 stop loads reload", v, 32'd100);
    endtask

    task automatic t_onemhz();
        logic [31:0] v;
        ld(2, 32'd50);
        wr(12, 32'h3 << 4);
        step(5);
        rd(chaddr(2,0), v); chk("R6 no strobe no step", v, 32'd50);
        tick_1mhz = 1'b1; step(3); tick_1mhz = 1'b0;
        rd(chaddr(2,0), v); chk("R6 three strobes", v, 32'd47);
        step(2);
        rd(chaddr(2,0), v); chk("R6 held without strobe", v, 32'd47);
        wr(12, 0);
        rd(chaddr(2,0), v); chk("R4 stop reloads ch2", v, 32'd50);
        step(4);
        rd(chaddr(2,0), v); chk("R12 stopped holds", v, 32'd50);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        ld(8, 32'd3);
        wr(12, 32'h5 << 28);
        step(4);
        rd(chaddr(8,0), v); chk("R7 wrap reloads", v, 32'd3);
        chk("R7 irq pulse with enable", {31'h0, irq[7]}, 1);
        step(1);
        rd(chaddr(8,0), v); chk("R7 continues after wrap", v, 32'd2);
        chk("R7 irq one cycle", {31'h0, irq[7]}, 0);
        wr(12, 0);
        wr(12, 32'h1 << 28);
        step(4);
        chk("R7 no irq without enable", {31'h0, irq[7]}, 0);
        rd(chaddr(8,0), v); chk("R7 wrap without enable", v, 32'd3);
        wr(12, 0);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        ld(3, 32'd2);
        wr(12, 32'h5 << 8);
        step(2);
        rd(chaddr(3,0), v); chk("R11 reached zero", v, 0);
        wr(12, 0);
        rd(chaddr(3,0), v); chk("R11 stop wins, count=reload", v, 32'd2);
        chk("R11 no irq on collision", {31'h0, irq[2]}, 0);
        step(3);
        rd(chaddr(3,0), v); chk("R12 holds after collision", v, 32'd2);
    endtask

    task automatic t_match();
        wr(2, 32'd7);
        wr(3, 32'd4);
        ld(1, 32'd10);
        wr(12, 32'h3);
        chk("R10 no hits at 10", {30'h0, match1_hit[0], match2_hit[0]}, 0);
        tick_1mhz = 1'b1; step(3); tick_1mhz = 1'b0;
        chk("R10 cmp1 hit at 7", {30'h0, match1_hit[0], match2_hit[0]}, 2'b10);
        tick_1mhz = 1'b1; step(3); tick_1mhz = 1'b0;
        chk("R10 cmp2 hit at 4", {30'h0, match1_hit[0], match2_hit[0]}, 2'b01);
        wr(12, 0);
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_map();
        t_status_ro();
        t_ctrl_pack();
        t_free_run();
        t_onemhz();
        t_wrap();
        t_collision();
        t_match();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule